// File: doc/BRIEF.md
# External Trigger Timestamp Capture

This block watches a set of asynchronous trigger pins and records the moment each one fires. Every pin is first brought into the local clock domain, and then an edge detector looks for the transition that software has selected for that pin, either rising or falling. When the selected transition appears, the block copies the current 64-bit time value, which it takes as an input, into a 16-entry first-in first-out store that belongs to that pin.

Software drains each store through a pair of 32-bit read addresses. A read of the low word takes a private copy of the oldest entry and returns its lower half. The following read of the high word returns the upper half of that same copy and then removes the entry. The pair therefore stays consistent even when a new capture lands between the two reads.

A status word shows which stores are non-empty. A sticky event word records three things: a stored capture, the fill level reaching a programmable threshold, and a capture lost because the store was full. Event bits are cleared by writing ones to them. A time value of zero is treated as invalid. Reading an empty store returns zero.

Top module: `ext_trig_stamp`

## Requirements
- R1: Each trigger input goes through a two-flop synchroniser and then an edge detector. Bit 8+i of the control word (address 0) selects the falling edge for input i when it is 1, and the rising edge when it is 0. The opposite edge is ignored. The time value stored is the one present at the third rising clock edge after the pin changes.
- R2: Bit 24+i of the status word (address 2), and output `ts_valid[i]`, are 1 exactly while store i holds at least one entry.
- R3: A read of address 4+2i with store i non-empty returns bits 31:0 of the oldest entry and latches that entry. A following read of address 5+2i returns bits 63:32 of the latched entry and removes it, even if new captures arrived in between.
- R4: A read of address 5+2i that is not preceded by a latching low read returns zero and removes nothing.
- R5: A low-word read of an empty store returns zero and changes nothing.
- R6: Each stored capture on input i sets event bit 24+i.
- R7: Event bit 20+i is set when a stored capture brings store i's fill level equal to the threshold word (address 1, 5 bits). The threshold resets to 7.
- R8: A capture on input i while store i is full, with no removal in the same cycle, is dropped. It sets event bit 28+i and leaves the stored entries unchanged.
- R9: A selected edge seen while the time input is all zero is ignored. Nothing is stored and no event is set.
- R10: Event bits (address 3, also on `evt_o`) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: Register reads return data in the same cycle as `rd_en`. The control word reads back its edge-select bits. Any read with `rd_en` low returns zero.
- R12: Each store returns entries in capture order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time value to stamp |
| trig_in | input | NCH | Asynchronous trigger pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; a TS read has side effects |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Read data, valid in the same cycle as `rd_en` |
| ts_valid | output | NCH | Per-input store non-empty |
| evt_o | output | 32 | Sticky event word |

## Verification
A corrupted fill count or pointer appears on `ts_valid` or `evt_o` in the cycle after the faulty update, because the bench compares both against its queue model on every clock. A read-state fault, such as a pop without a latch or a lost hold register, appears on `rd_data` at the next high-word read. Edge-selection and synchroniser-depth errors make the stored time differ from the model by one or more counts, and this is caught when that entry is drained. A threshold or overflow decision that is off by one shows on the event word in the cycle of the capture concerned.

// File: rtl/ets_pkg.sv
package ets_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_THR  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
    localparam logic [ADDR_W-1:0] A_EVT  = 4'd3;
    localparam int A_TS_BASE  = 4;
    localparam int BIT_FALL   = 8;
    localparam int BIT_THR    = 20;
    localparam int BIT_CAP    = 24;
    localparam int BIT_OVF    = 28;
    localparam int BIT_VALID  = 24;
endpackage

// File: rtl/ets_sync_edge.sv
module ets_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic hit
);
    // [0],[1]: synchroniser; [2]: previous synchronised sample
    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], din};
    end

    assign hit = fall_sel ? (sh_q[2] & ~sh_q[1]) : (sh_q[1] & ~sh_q[2]);
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0] lvl_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (push) wptr_q <= bump(wptr_q);
            if (pop)  rptr_q <= bump(rptr_q);
            case ({push, pop})
                2'b10:   lvl_q <= lvl_q + LVL_W'(1);
                2'b01:   lvl_q <= lvl_q - LVL_W'(1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    assign head  = mem[rptr_q];
    assign level = lvl_q;
    assign full  = (lvl_q == LVL_W'(DEPTH));
    assign empty = (lvl_q == '0);
endmodule

// File: rtl/ets_chan.sv
module ets_chan
    import ets_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              fall_sel,
    input  logic [TW-1:0]     time_now,
    input  logic [LVL_W-1:0]  thr,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic              cap_ev,
    output logic              thr_ev,
    output logic              ovf_ev,
    output logic              valid,
    output logic [DATA_W-1:0] lo_word,
    output logic [DATA_W-1:0] hi_word
);
    logic              hit, got, room, push, pop, latch;
    logic              full, empty;
    logic [TW-1:0]     head, hold_q;
    logic [LVL_W-1:0]  level;
    logic [LVL_W:0]    next_lvl;
    rd_state_e         st_q, st_nx;

    ets_sync_edge u_edge (
        .clk(clk), .rst_n(rst_n), .din(trig), .fall_sel(fall_sel), .hit(hit)
    );

    ets_fifo #(.DEPTH(DEPTH), .W(TW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(time_now),
        .head(head), .level(level), .full(full), .empty(empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_nx;
    end

    // transitions and read-side actions
    always_comb begin
        st_nx = st_q;
        pop   = 1'b0;
        latch = 1'b0;
        unique case (st_q)
            RD_IDLE: begin
                if (rd_lo && !empty) begin
                    latch = 1'b1;
                    st_nx = RD_HELD;
                end
            end
            RD_HELD: begin
                if (rd_hi) begin
                    pop   = 1'b1;
                    st_nx = RD_IDLE;
                end else if (rd_lo) begin
                    latch = 1'b1;
                end
            end
            default: st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= '0;
        else if (latch) hold_q <= head;
    end

    // outputs
    always_comb begin
        got      = hit && (time_now != '0);
        room     = !full || pop;
        push     = got && room;
        next_lvl = {1'b0, level} + (LVL_W+1)'(1) - (LVL_W+1)'(pop);
        cap_ev   = push;
        thr_ev   = push && (next_lvl == {1'b0, thr});
        ovf_ev   = got && !room;
        valid    = !empty;
        lo_word  = empty ? '0 : head[DATA_W-1:0];
        hi_word  = (st_q == RD_HELD) ? hold_q[TW-1:TW-DATA_W] : '0;
    end
endmodule

// File: rtl/ext_trig_stamp.sv
module ext_trig_stamp
    import ets_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DEPTH   = 16,
    parameter int TW      = 64,
    parameter int THR_DEF = 7,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     time_now,
    input  logic [NCH-1:0]    trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    ts_valid,
    output logic [DATA_W-1:0] evt_o
);
    logic [NCH-1:0]    fall_q;
    logic [LVL_W-1:0]  thr_q;
    logic [DATA_W-1:0] evt_q, evt_set, evt_clr;
    logic [NCH-1:0]    cap_ev, thr_ev, ovf_ev, rd_lo, rd_hi;
    logic [DATA_W-1:0] lo_w [NCH];
    logic [DATA_W-1:0] hi_w [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign rd_lo[i] = rd_en && (rd_addr == ADDR_W'(A_TS_BASE + 2*i));
        assign rd_hi[i] = rd_en && (rd_addr == ADDR_W'(A_TS_BASE + 2*i + 1));

        ets_chan #(.DEPTH(DEPTH), .TW(TW)) u_chan (
            .clk(clk), .rst_n(rst_n), .trig(trig_in[i]), .fall_sel(fall_q[i]),
            .time_now(time_now), .thr(thr_q), .rd_lo(rd_lo[i]), .rd_hi(rd_hi[i]),
            .cap_ev(cap_ev[i]), .thr_ev(thr_ev[i]), .ovf_ev(ovf_ev[i]),
            .valid(ts_valid[i]), .lo_word(lo_w[i]), .hi_word(hi_w[i])
        );
    end

    always_comb begin
        evt_set = '0;
        for (int i = 0; i < NCH; i++) begin
            evt_set[BIT_CAP + i] = cap_ev[i];
            evt_set[BIT_THR + i] = thr_ev[i];
            evt_set[BIT_OVF + i] = ovf_ev[i];
        end
        evt_clr = (wr_en && wr_addr == A_EVT) ? wr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
            thr_q  <= LVL_W'(THR_DEF);
            evt_q  <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) fall_q <= wr_data[BIT_FALL +: NCH];
            if (wr_en && wr_addr == A_THR)  thr_q  <= wr_data[LVL_W-1:0];
            evt_q <= (evt_q & ~evt_clr) | evt_set;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                A_CTRL:  rd_data[BIT_FALL +: NCH] = fall_q;
                A_THR:   rd_data[LVL_W-1:0] = thr_q;
                A_STAT:  rd_data[BIT_VALID +: NCH] = ts_valid;
                A_EVT:   rd_data = evt_q;
                default: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (rd_lo[i]) rd_data = lo_w[i];
                        if (rd_hi[i]) rd_data = hi_w[i];
                    end
                end
            endcase
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/ets_checker.sv
module ets_checker #(
    parameter int NCH = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic        rd_en,
    input logic [3:0]  rd_addr,
    input logic [31:0] rd_data,
    input logic [NCH-1:0] ts_valid,
    input logic [31:0] evt_o
);
    // R10: without a write to the event word no set bit drops
    p_evt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 4'd3) |=> ((evt_o & $past(evt_o)) == $past(evt_o)));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        p_cap_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_o[24+i]) |-> ts_valid[i]);
        p_thr_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_o[20+i]) |-> ts_valid[i]);
        p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_o[28+i]) |-> ts_valid[i]);
        p_empty_lo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == 4'(4 + 2*i) && !ts_valid[i]) |-> (rd_data == 32'd0));
    end
endmodule

bind ext_trig_stamp ets_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ts_valid(ts_valid), .evt_o(evt_o)
);

// File: tb/ext_trig_stamp_tb_top.sv
module ext_trig_stamp_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tcount = 64'h0000_0001_0000_0100;
    logic        zero_time = 1'b0;
    logic [63:0] time_now;
    logic [1:0]  trig_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  ts_valid;
    logic [31:0] evt_o;

    int checks = 0;
    int fails  = 0;

    assign time_now = zero_time ? 64'd0 : tcount;
    always #(CLK_P/2) clk = ~clk;
    always @(negedge clk) tcount <= tcount + 64'd3;

    ext_trig_stamp dut_i (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .trig_in(trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ts_valid(ts_valid), .evt_o(evt_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] mq [2][$];
    logic [1:0]  m_s1 = '0, m_s2 = '0, m_s3 = '0, m_fall = '0, m_held = '0;
    logic [63:0] m_hold [2];
    int          m_thr = 7;
    logic [31:0] m_evt = '0, m_set;
    logic        m_edge;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_fall = '0; m_held = '0;
            m_thr = 7; m_evt = '0;
            for (int c = 0; c < 2; c++) mq[c].delete();
        end else begin
            m_set = '0;
            for (int c = 0; c < 2; c++) begin
                m_edge = m_fall[c] ? (m_s3[c] && !m_s2[c]) : (m_s2[c] && !m_s3[c]);
                if (rd_en && rd_addr == 4'(5 + 2*c) && m_held[c]) begin
                    void'(mq[c].pop_front());
                    m_held[c] = 1'b0;
                end else if (rd_en && rd_addr == 4'(4 + 2*c) && mq[c].size() > 0) begin
                    m_hold[c] = mq[c][0];
                    m_held[c] = 1'b1;
                end
                if (m_edge && time_now != 64'd0) begin
                    if (mq[c].size() < DEPTH) begin
                        mq[c].push_back(time_now);
                        m_set[24+c] = 1'b1;
                        if (mq[c].size() == m_thr) m_set[20+c] = 1'b1;
                    end else begin
                        m_set[28+c] = 1'b1;
                    end
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in;
            if (wr_en && wr_addr == 4'd0) m_fall = wr_data[9:8];
            if (wr_en && wr_addr == 4'd1) m_thr = int'(wr_data[4:0]);
            if (wr_en && wr_addr == 4'd3) m_evt = m_evt & ~wr_data;
            m_evt = m_evt | m_set;
        end
    end

    // per-clock comparison of status and events
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (ts_valid[c] !== (mq[c].size() > 0)) begin
                    fails++;
                    $display("FAIL R2 ts_valid[%0d] act=%b exp=%b", c, ts_valid[c], mq[c].size() > 0);
                end
            end
            checks++;
            if (evt_o !== m_evt) begin
                fails++;
                $display("FAIL R10/R6/R7/R8 evt_o act=%h exp=%h", evt_o, m_evt);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, rd_data, exp);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_lo(input int c);
        return (mq[c].size() > 0) ? mq[c][0][31:0] : 32'd0;
    endfunction

    function automatic logic [31:0] exp_hi(input int c);
        return m_held[c] ? m_hold[c][63:32] : 32'd0;
    endfunction

    task automatic pulse(input int c);
        trig_in[c] = 1'b1; tick(4);
        trig_in[c] = 1'b0; tick(4);
    endtask

    task automatic pop_pair(input int c, input string tag);
        rd_chk(4'(4 + 2*c), exp_lo(c), tag);
        rd_chk(4'(5 + 2*c), exp_hi(c), tag);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog all-requirements act=hung exp=finished");
        finish_run();
    end

    // ---------------- test sequence ----------------
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // reset state
        rd_chk(4'd2, 32'd0, "R2 reset status");
        rd_chk(4'd1, 32'd7, "R7 threshold reset");
        rd_chk(4'd3, 32'd0, "R10 reset events");
        rd_chk(4'd0, 32'd0, "R11 reset control");
        rd_en = 1'b0;
        checks++;
        if (rd_data !== 32'd0) begin fails++; $display("FAIL R11 idle read act=%h exp=0", rd_data); end

        // R1: input 1 falling edge selected
        wr(4'd0, 32'h0000_0200);
        rd_chk(4'd0, 32'h0000_0200, "R11 control readback");
        trig_in[1] = 1'b1; tick(5);
        rd_chk(4'd2, 32'd0, "R1 rising ignored on falling-select input");
        trig_in[1] = 1'b0; tick(5);
        rd_chk(4'd2, 32'h0200_0000, "R1 falling edge captured");

        // R1/R12: three rising captures on input 0
        pulse(0); pulse(0); pulse(0);
        checks++;
        if (mq[0].size() != 3) begin fails++; $display("FAIL R1 model count act=%0d exp=3", mq[0].size()); end
        rd_chk(4'd2, 32'h0300_0000, "R2 both valid");
        pop_pair(0, "R12 first in order");

        // R3: capture between low and high reads
        rd_chk(4'd4, exp_lo(0), "R3 low latch");
        pulse(0);
        rd_chk(4'd5, exp_hi(0), "R3 high consistent after new capture");
        pop_pair(0, "R12 next in order");

        // R4: high without low on input 1
        rd_chk(4'd7, 32'd0, "R4 high without low");
        checks++;
        if (ts_valid[1] !== 1'b1) begin fails++; $display("FAIL R4 entry lost act=%b exp=1", ts_valid[1]); end
        pop_pair(1, "R3 input 1 pair");

        // R5: empty store
        rd_chk(4'd6, 32'd0, "R5 empty low read");
        rd_chk(4'd7, 32'd0, "R5 empty high read");

        // R10: clear all events
        wr(4'd3, 32'hFFFF_FFFF);
        rd_chk(4'd3, 32'd0, "R10 write-one clear");

        // drain input 0
        while (mq[0].size() > 0) pop_pair(0, "R12 drain");
        wr(4'd3, 32'hFFFF_FFFF);

        // R7/R8: fill input 0
        for (int k = 0; k < 7; k++) pulse(0);
        rd_chk(4'd3, 32'h0110_0000, "R7 threshold reached at 7");
        wr(4'd3, 32'h0010_0000);
        rd_chk(4'd3, 32'h0100_0000, "R10 selective clear");
        for (int k = 7; k < 16; k++) pulse(0);
        rd_chk(4'd3, 32'h0100_0000, "R8 no overflow at 16");
        pulse(0);
        rd_chk(4'd3, 32'h1100_0000, "R8 overflow on 17th");
        checks++;
        if (mq[0].size() != 16) begin fails++; $display("FAIL R8 kept entries act=%0d exp=16", mq[0].size()); end
        while (mq[0].size() > 0) pop_pair(0, "R8 R12 contents after overflow");
        rd_chk(4'd2, 32'd0, "R2 empty after drain");

        // R9: zero time ignored
        wr(4'd3, 32'hFFFF_FFFF);
        zero_time = 1'b1;
        trig_in[1] = 1'b1; tick(4);
        trig_in[1] = 1'b0; tick(5);
        zero_time = 1'b0;
        rd_chk(4'd2, 32'd0, "R9 zero time not stored");
        rd_chk(4'd3, 32'd0, "R9 zero time no event");

        // R7: programmed threshold on input 1
        wr(4'd1, 32'd2);
        rd_chk(4'd1, 32'd2, "R7 threshold readback");
        pulse(1); pulse(1);
        rd_chk(4'd3, 32'h0220_0000, "R7 threshold 2 on input 1");
        pop_pair(1, "R12 input 1 first");
        pop_pair(1, "R12 input 1 second");

        tick(3);
        finish_run();
    end
endmodule